// File: doc/BRIEF.md
# Multi-level page table walker

This block translates a virtual address into a physical address. It reads a radix page table that sits in memory behind a simple read/write port. A walk starts from a root table frame. It descends one level per memory read, from the top level down to level 1. A level-2 entry may mark a 2 MiB page, and the walk then ends there. Each table holds 512 eight-byte entries. Physical addresses are 36 bits wide. A configuration input selects four or five levels. A second input says whether the no-execute bit is legal.

When the walk finishes, the block reports four results: the final entry, the level where the walk stopped, the translated physical address, and a fault kind (none, not present, or reserved bit). The block updates the accessed and dirty flags of the entries it visits, and it writes an entry back only when that update changes the entry. Permission checks belong to a separate checker that uses the reported entry. The block has no translation caching.

Top module: `pgwalk_top`

## Requirements
- R1: `req_ready` is high exactly when the block is idle, and a request is taken when `req_valid` and `req_ready` are both high. Each walk ends with `done` high for exactly one cycle, and `req_ready` returns high in that same cycle.
- R2: The first memory read of a walk goes to address `{root_frame, 12'b0} + 8*index`. The walk starts at level 5 when `cfg_five_level` is 1 and at level 4 when it is 0. The index at level L is `req_vaddr[12+9*(L-1) +: 9]`.
- R3: At every level above the leaf, the next table frame is taken from entry bits [35:12], and the level drops by one. A 4 KiB walk ends at level 1, and `res_paddr = {entry[35:12], vaddr[11:0]}`.
- R4: A present, non-reserved level-2 entry with bit 7 set ends the walk at level 2 with no fault, and `res_paddr = {entry[35:21], vaddr[20:0]}`. Bit 7 has no effect at any other level.
- R5: An entry with bit 0 clear ends the walk with `res_fault_kind` = 1 (not present). `res_level` is then that entry's level, and `res_entry` is the entry as read.
- R6: A present entry with bit 51 or bit 36 set ends the walk with `res_fault_kind` = 2 (reserved bit). The same holds for a level-2 large-page entry with bit 13 set. Bit 13 in a level-2 entry that points to a table causes no fault.
- R7: Bit 63 set in a present entry is a reserved-bit fault (kind 2) when `cfg_nx_en` is 0. When `cfg_nx_en` is 1 it causes no fault.
- R8: When the walk passes a non-leaf level-2 entry that is present and has no reserved bit set, the block sets that entry's bit 5 (accessed) in memory. This happens even if the walk later faults at level 1.
- R9: A leaf that does not fault gets bit 5 set, and also bit 6 (dirty) on a write request. `res_entry` then holds the updated value. An entry that faults is never written.
- R10: An entry is written back only when the update changes its value. Entries above level 2 are never written.
- R11: Only one memory transaction is outstanding at a time. Once `mem_valid` is high, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ready` is high. Read data is taken in the cycle where both are high.
- R12: `res_fault_kind`, `res_level`, `res_entry` and `res_paddr` change only on the edge that raises `done`. They hold their values until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr | input | 57 | Virtual address to translate |
| req_write | input | 1 | Access is a write (dirty bit update) |
| cfg_five_level | input | 1 | 1: five-level walk, 0: four-level walk |
| cfg_nx_en | input | 1 | 1: bit 63 legal, 0: bit 63 reserved |
| root_frame | input | 24 | Frame number of the top-level table |
| mem_valid | output | 1 | Memory transaction request |
| mem_ready | input | 1 | Memory accepts/completes the transaction |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 36 | Byte address of the entry |
| mem_wdata | output | 64 | Entry value to write |
| mem_rdata | input | 64 | Entry value read, valid with mem_ready |
| done | output | 1 | One-cycle end-of-walk pulse |
| res_fault_kind | output | 2 | 0 none, 1 not present, 2 reserved bit |
| res_level | output | 3 | Level where the walk stopped |
| res_entry | output | 64 | Final entry (updated value on success) |
| res_paddr | output | 36 | Translated physical address, 0 on fault |

## Verification
The random walks build a fresh table path for each request. Each entry is dropped with some probability, given a random large-page flag at level 2, stray reserved bits, and preset accessed and dirty flags. Memory ready stalls are random, and the level count, no-execute enable and write flag are random too. Together these separate a correct stopping level from an early or late stop, and a correct write-back count from extra or missing writes.

Directed paths isolate the corner cases:
- all flags already set, so no write may occur;
- a not-present leaf below a fresh level-2 entry, to test the pass-through accessed bit;
- bit 13 on a large and on a non-large level-2 entry;
- bit 63 with the no-execute enable on and off;
- a five-level path, to test the starting index.

// File: rtl/pgwalk_pkg.sv
// Shared entry format constants and state/fault encodings for the walker.
// Assumes 64-bit table entries; bit positions are fixed by the entry format.
package pgwalk_pkg;
    localparam int PTE_W       = 64;
    localparam int PTE_P       = 0;
    localparam int PTE_ACC     = 5;
    localparam int PTE_DIRTY   = 6;
    localparam int PTE_BIG     = 7;
    localparam int PTE_BIG_RSV = 13;
    localparam int PTE_RSV_LO  = 36;
    localparam int PTE_RSV_HI  = 51;
    localparam int PTE_XD      = 63;
    localparam int ENT_SH      = 3;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_RSVD   = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;
endpackage

// File: rtl/pgwalk_addr_gen.sv
// Entry address generator: selects the per-level index from the virtual page
// number and forms the byte address of the entry inside the current table.
// Assumes tables are page aligned and entries are 8 bytes wide.
module pgwalk_addr_gen
    import pgwalk_pkg::*;
#(
    parameter int PA_W     = 36,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LVL_MAX  = 5,
    parameter int LVL_W    = 3,
    parameter int VPN_W    = 45
) (
    input  logic [VPN_W-1:0]         vpn,
    input  logic [LVL_W-1:0]         level,
    input  logic [PA_W-PG_SHIFT-1:0] frame,
    output logic [PA_W-1:0]          ent_addr
);
    logic [IDX_W-1:0] idx_tbl [LVL_MAX];
    logic [IDX_W-1:0] idx_sel;

    // one index slice per level
    for (genvar g = 0; g < LVL_MAX; g++) begin : g_slice
        assign idx_tbl[g] = vpn[g*IDX_W +: IDX_W];
    end

    // pick the slice for the current level
    always_comb begin
        idx_sel = '0;
        for (int k = 0; k < LVL_MAX; k++) begin
            if (level == LVL_W'(k + 1)) idx_sel = idx_tbl[k];
        end
    end

    // table base plus scaled index
    always_comb begin
        ent_addr = {frame, {PG_SHIFT{1'b0}}} | (PA_W'(idx_sel) << ENT_SH);
    end
endmodule

// File: rtl/pgwalk_entry_chk.sv
// Entry classifier: decides presence, reserved-bit faults, leaf status,
// the accessed/dirty update and the translated address for one entry.
// Assumes level 2 is the only level where a large page may end the walk.
module pgwalk_entry_chk
    import pgwalk_pkg::*;
#(
    parameter int PA_W     = 36,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LVL_W    = 3
) (
    input  logic [PTE_W-1:0]          entry,
    input  logic [LVL_W-1:0]          level,
    input  logic                      nx_en,
    input  logic                      is_write,
    input  logic [PG_SHIFT+IDX_W-1:0] va_off,
    output logic [1:0]                fault_kind,
    output logic                      leaf,
    output logic [PTE_W-1:0]          upd_entry,
    output logic                      wb_need,
    output logic [PA_W-PG_SHIFT-1:0]  next_frame,
    output logic [PA_W-1:0]           leaf_paddr
);
    localparam int BIG_SH = PG_SHIFT + IDX_W;

    logic present;
    logic big;
    logic rsv;
    logic at_l2;

    // classify the entry
    always_comb begin
        at_l2   = (level == LVL_W'(2));
        present = entry[PTE_P];
        big     = at_l2 && entry[PTE_BIG];
        rsv     = entry[PTE_RSV_HI] | entry[PTE_RSV_LO]
                | (big & entry[PTE_BIG_RSV])
                | (~nx_en & entry[PTE_XD]);
        leaf    = (level == LVL_W'(1)) || big;
    end

    // fault code, absence first
    always_comb begin
        if (!present)  fault_kind = FLT_ABSENT;
        else if (rsv)  fault_kind = FLT_RSVD;
        else           fault_kind = FLT_NONE;
    end

    // accessed/dirty update, applied only to a clean entry
    always_comb begin
        upd_entry = entry;
        if (present && !rsv) begin
            if (leaf) begin
                upd_entry[PTE_ACC] = 1'b1;
                if (is_write) upd_entry[PTE_DIRTY] = 1'b1;
            end else if (at_l2) begin
                upd_entry[PTE_ACC] = 1'b1;
            end
        end
        wb_need = (upd_entry != entry);
    end

    // next table frame and leaf physical address
    always_comb begin
        next_frame = entry[PA_W-1:PG_SHIFT];
        if (big) leaf_paddr = {entry[PA_W-1:BIG_SH], va_off[BIG_SH-1:0]};
        else     leaf_paddr = {entry[PA_W-1:PG_SHIFT], va_off[PG_SHIFT-1:0]};
    end
endmodule

// File: rtl/pgwalk_ctrl.sv
// Walk sequencer: accepts a request, issues one read per level, a write-back
// when the classifier asks for one, and registers the final result.
// Assumes mem_rdata is valid in the cycle where mem_valid and mem_ready meet.
module pgwalk_ctrl
    import pgwalk_pkg::*;
#(
    parameter int PA_W     = 36,
    parameter int PG_SHIFT = 12,
    parameter int LVL_MAX  = 5,
    parameter int LVL_W    = 3,
    parameter int VA_W     = 57
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic                      req_write,
    input  logic                      cfg_five_level,
    input  logic                      cfg_nx_en,
    input  logic [PA_W-PG_SHIFT-1:0]  root_frame,
    input  logic                      mem_ready,
    input  logic [PTE_W-1:0]          mem_rdata,
    output logic                      mem_valid,
    output logic                      mem_we,
    output logic [PTE_W-1:0]          mem_wdata,
    input  logic [1:0]                c_fault,
    input  logic                      c_leaf,
    input  logic [PTE_W-1:0]          c_upd,
    input  logic                      c_wb,
    input  logic [PA_W-PG_SHIFT-1:0]  c_next_frame,
    input  logic [PA_W-1:0]           c_paddr,
    output logic [LVL_W-1:0]          cur_level,
    output logic [PA_W-PG_SHIFT-1:0]  cur_frame,
    output logic [VA_W-1:0]           cur_va,
    output logic                      cur_nx,
    output logic                      cur_write,
    output logic                      done,
    output logic [1:0]                res_fault_kind,
    output logic [LVL_W-1:0]          res_level,
    output logic [PTE_W-1:0]          res_entry,
    output logic [PA_W-1:0]           res_paddr
);
    st_e                     state_q;
    logic [PTE_W-1:0]        wbuf_q;
    logic                    leaf_q;
    logic [PA_W-PG_SHIFT-1:0] nfrm_q;
    logic [PA_W-1:0]         pa_q;

    // handshake outputs follow the state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_valid = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WRITE);
        mem_wdata = wbuf_q;
    end

    // walk sequencing and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_IDLE;
            cur_level      <= '0;
            cur_frame      <= '0;
            cur_va         <= '0;
            cur_nx         <= 1'b0;
            cur_write      <= 1'b0;
            wbuf_q         <= '0;
            leaf_q         <= 1'b0;
            nfrm_q         <= '0;
            pa_q           <= '0;
            done           <= 1'b0;
            res_fault_kind <= FLT_NONE;
            res_level      <= '0;
            res_entry      <= '0;
            res_paddr      <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_va    <= req_vaddr;
                        cur_write <= req_write;
                        cur_nx    <= cfg_nx_en;
                        cur_frame <= root_frame;
                        cur_level <= cfg_five_level ? LVL_W'(LVL_MAX) : LVL_W'(LVL_MAX - 1);
                        state_q   <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        if (c_fault != FLT_NONE) begin
                            state_q        <= ST_IDLE;
                            done           <= 1'b1;
                            res_fault_kind <= c_fault;
                            res_level      <= cur_level;
                            res_entry      <= mem_rdata;
                            res_paddr      <= '0;
                        end else if (c_wb) begin
                            wbuf_q  <= c_upd;
                            leaf_q  <= c_leaf;
                            nfrm_q  <= c_next_frame;
                            pa_q    <= c_paddr;
                            state_q <= ST_WRITE;
                        end else if (c_leaf) begin
                            state_q        <= ST_IDLE;
                            done           <= 1'b1;
                            res_fault_kind <= FLT_NONE;
                            res_level      <= cur_level;
                            res_entry      <= mem_rdata;
                            res_paddr      <= c_paddr;
                        end else begin
                            cur_frame <= c_next_frame;
                            cur_level <= cur_level - LVL_W'(1);
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        if (leaf_q) begin
                            state_q        <= ST_IDLE;
                            done           <= 1'b1;
                            res_fault_kind <= FLT_NONE;
                            res_level      <= cur_level;
                            res_entry      <= wbuf_q;
                            res_paddr      <= pa_q;
                        end else begin
                            cur_frame <= nfrm_q;
                            cur_level <= cur_level - LVL_W'(1);
                            state_q   <= ST_READ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgwalk_top.sv
// Page table walker top: wires the sequencer, the entry address generator
// and the entry classifier. One memory transaction is in flight at a time.
// Assumes the memory port returns read data with its ready signal.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int PA_W     = 36,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LVL_MAX  = 5,
    localparam int VA_W    = PG_SHIFT + IDX_W * LVL_MAX,
    localparam int LVL_W   = $clog2(LVL_MAX + 1),
    localparam int FRM_W   = PA_W - PG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              cfg_five_level,
    input  logic              cfg_nx_en,
    input  logic [FRM_W-1:0]  root_frame,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic [1:0]        res_fault_kind,
    output logic [LVL_W-1:0]  res_level,
    output logic [63:0]       res_entry,
    output logic [PA_W-1:0]   res_paddr
);
    localparam int OFF_W = PG_SHIFT + IDX_W;
    localparam int VPN_W = VA_W - PG_SHIFT;

    logic [LVL_W-1:0] cur_level;
    logic [FRM_W-1:0] cur_frame;
    logic [VA_W-1:0]  cur_va;
    logic             cur_nx;
    logic             cur_write;
    logic [1:0]       c_fault;
    logic             c_leaf;
    logic [63:0]      c_upd;
    logic             c_wb;
    logic [FRM_W-1:0] c_next_frame;
    logic [PA_W-1:0]  c_paddr;

    pgwalk_ctrl #(
        .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .LVL_MAX(LVL_MAX),
        .LVL_W(LVL_W), .VA_W(VA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .cfg_five_level(cfg_five_level), .cfg_nx_en(cfg_nx_en),
        .root_frame(root_frame),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .c_fault(c_fault), .c_leaf(c_leaf), .c_upd(c_upd), .c_wb(c_wb),
        .c_next_frame(c_next_frame), .c_paddr(c_paddr),
        .cur_level(cur_level), .cur_frame(cur_frame), .cur_va(cur_va),
        .cur_nx(cur_nx), .cur_write(cur_write),
        .done(done), .res_fault_kind(res_fault_kind), .res_level(res_level),
        .res_entry(res_entry), .res_paddr(res_paddr)
    );

    pgwalk_addr_gen #(
        .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
        .LVL_MAX(LVL_MAX), .LVL_W(LVL_W), .VPN_W(VPN_W)
    ) u_addr (
        .vpn(cur_va[VA_W-1:PG_SHIFT]), .level(cur_level),
        .frame(cur_frame), .ent_addr(mem_addr)
    );

    pgwalk_entry_chk #(
        .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W), .LVL_W(LVL_W)
    ) u_chk (
        .entry(mem_rdata), .level(cur_level), .nx_en(cur_nx),
        .is_write(cur_write), .va_off(cur_va[OFF_W-1:0]),
        .fault_kind(c_fault), .leaf(c_leaf), .upd_entry(c_upd),
        .wb_need(c_wb), .next_frame(c_next_frame), .leaf_paddr(c_paddr)
    );
endmodule

// File: rtl/pgwalk_sva.sv
// Property checker for the walker ports, bound into every pgwalk_top.
// Assumes synchronous active-low reset; all properties are off in reset.
module pgwalk_sva #(
    parameter int PA_W  = 36,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             done,
    input logic [1:0]       res_fault_kind,
    input logic [LVL_W-1:0] res_level,
    input logic [63:0]      res_entry,
    input logic [PA_W-1:0]  res_paddr,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [63:0]      mem_wdata
);
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_we) && $stable(mem_wdata)));

    a_r4_leaf_level: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault_kind == 2'd0) |->
            (res_level == LVL_W'(1)) || (res_level == LVL_W'(2) && res_entry[7]));

    a_r5_absent_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault_kind == 2'd1) |-> !res_entry[0]);

    a_r6_reserved_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault_kind == 2'd2) |->
            (res_entry[0] && (res_entry[51] || res_entry[36]
                              || res_entry[13] || res_entry[63])));

    a_r9_leaf_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_fault_kind == 2'd0) |-> res_entry[5]);

    a_r8_written_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (mem_wdata[0] && mem_wdata[5]));

    a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done || ($stable(res_entry) && $stable(res_paddr)
                           && $stable(res_level) && $stable(res_fault_kind))));
endmodule

bind pgwalk_top pgwalk_sva #(.PA_W(PA_W), .LVL_W(LVL_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .res_fault_kind(res_fault_kind), .res_level(res_level),
    .res_entry(res_entry), .res_paddr(res_paddr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/pgwalk_top_tb.sv
// Self-checking bench: sparse memory model with random stalls, random and
// directed table paths, and a bench-side walk model computing expected values.
module pgwalk_top_tb_top;
    localparam logic [35:0] ROOT = 36'h0_0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [56:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        cfg_five_level = 1'b0;
    logic        cfg_nx_en = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_we;
    logic [35:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [1:0]  res_fault_kind;
    logic [2:0]  res_level;
    logic [63:0] res_entry;
    logic [35:0] res_paddr;

    always #5 clk = ~clk;

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .cfg_five_level(cfg_five_level), .cfg_nx_en(cfg_nx_en),
        .root_frame(ROOT[35:12]),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .res_fault_kind(res_fault_kind), .res_level(res_level),
        .res_entry(res_entry), .res_paddr(res_paddr)
    );

    logic [63:0] dmem [logic [35:0]];
    logic [63:0] rmem [logic [35:0]];
    int          n_chk = 0;
    int          n_bad = 0;
    int          wr_cnt = 0;
    bit          first_seen = 1'b0;
    logic [35:0] first_addr = '0;
    int          cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // memory model: random ready, transaction applied when both sides agree
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
        end else begin
            mem_ready = (($urandom % 10) < 7);
            if (mem_valid && mem_ready) begin
                if (!first_seen) begin
                    first_seen = 1'b1;
                    first_addr = mem_addr;
                end
                if (mem_we) begin
                    dmem[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = dmem.exists(mem_addr) ? dmem[mem_addr] : 64'd0;
                end
            end
        end
    end

    // global watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] ent_addr(logic [35:0] base, logic [56:0] va, int lv);
        logic [8:0] ix;
        ix = 9'((va >> (12 + 9 * (lv - 1))) & 57'h1ff);
        return {base[35:12], 12'h000} | {24'h0, ix, 3'b000};
    endfunction

    function automatic logic [35:0] tbl(int lv, int top);
        return (lv == top) ? ROOT : (36'h0_0020_0000 + 36'(lv) * 36'h1000);
    endfunction

    function automatic logic [63:0] link(int lv, int top);
        return 64'h21 | {28'h0, tbl(lv - 1, top)};
    endfunction

    task automatic put(int lv, int top, logic [56:0] va, logic [63:0] e);
        logic [35:0] a;
        a = ent_addr(tbl(lv, top), va, lv);
        dmem[a] = e;
        rmem[a] = e;
    endtask

    // bench walk model built from the requirements
    function automatic void ref_walk(input logic [56:0] va, input bit wr, input bit five,
                                     input bit nx, output logic [1:0] kind,
                                     output logic [2:0] lvl, output logic [63:0] ent,
                                     output logic [35:0] pa, output int nwr);
        logic [35:0] base;
        int top;
        base = ROOT;
        top  = five ? 5 : 4;
        kind = 2'd0; lvl = 3'd0; ent = 64'd0; pa = 36'd0; nwr = 0;
        for (int lv = top; lv >= 1; lv--) begin
            logic [35:0] a;
            logic [63:0] e;
            logic [63:0] ne;
            bit big;
            bit rsv;
            a   = ent_addr(base, va, lv);
            e   = rmem.exists(a) ? rmem[a] : 64'd0;
            lvl = 3'(lv);
            ent = e;
            if (!e[0]) begin kind = 2'd1; return; end
            big = (lv == 2) && e[7];
            rsv = e[51] || e[36] || (big && e[13]) || (!nx && e[63]);
            if (rsv) begin kind = 2'd2; return; end
            if (lv == 1 || big) begin
                ne = e | 64'h20 | (wr ? 64'h40 : 64'h0);
                if (ne != e) begin rmem[a] = ne; nwr++; end
                ent = ne;
                pa  = big ? {e[35:21], va[20:0]} : {e[35:12], va[11:0]};
                return;
            end
            if (lv == 2) begin
                ne = e | 64'h20;
                if (ne != e) begin rmem[a] = ne; nwr++; end
            end
            base = {e[35:12], 12'h000};
        end
    endfunction

    function automatic int mem_diff();
        int n;
        n = (dmem.size() != rmem.size()) ? 1 : 0;
        foreach (rmem[k]) begin
            if (!dmem.exists(k)) n++;
            else if (dmem[k] !== rmem[k]) n++;
        end
        return n;
    endfunction

    task automatic run_walk(input logic [56:0] va, input bit wr, input bit five,
                            input bit nx, input string tag);
        logic [1:0]  xk;
        logic [2:0]  xl;
        logic [63:0] xe;
        logic [35:0] xp;
        logic [35:0] xfirst;
        logic [63:0] held;
        int          xn;
        int          w;
        xfirst = ent_addr(ROOT, va, five ? 5 : 4);
        ref_walk(va, wr, five, nx, xk, xl, xe, xp, xn);
        wr_cnt = 0;
        first_seen = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
        req_vaddr = va; req_write = wr; cfg_five_level = five; cfg_nx_en = nx;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!done && w < 3000) begin
            @(negedge clk);
            w++;
        end
        chk(done == 1'b1, "R1", "walk finished", 64'(done), 64'd1);
        chk(first_addr == xfirst, "R2", "first entry address", 64'(first_addr), 64'(xfirst));
        chk(res_fault_kind == xk, tag, "fault kind", 64'(res_fault_kind), 64'(xk));
        chk(res_level == xl, tag, "stop level", 64'(res_level), 64'(xl));
        chk(res_entry == xe, tag, "final entry", res_entry, xe);
        chk(res_paddr == xp, tag, "physical address", 64'(res_paddr), 64'(xp));
        chk(wr_cnt == xn, tag, "write-back count", 64'(wr_cnt), 64'(xn));
        chk(mem_diff() == 0, tag, "memory image", 64'(mem_diff()), 64'd0);
        held = res_entry;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done single cycle", 64'(done), 64'd0);
        chk(res_entry == held, "R12", "result held", res_entry, held);
    endtask

    task automatic clear_mem();
        dmem.delete();
        rmem.delete();
    endtask

    task automatic upper_chain(logic [56:0] va, int top);
        clear_mem();
        for (int lv = top; lv >= 3; lv--) put(lv, top, va, link(lv, top));
    endtask

    task automatic random_walk();
        logic [56:0] va;
        bit five;
        int top;
        va   = {25'($urandom), 32'($urandom)};
        five = $urandom % 2;
        top  = five ? 5 : 4;
        clear_mem();
        for (int lv = top; lv >= 1; lv--) begin
            logic [63:0] e;
            int r;
            e = 64'd0;
            if (lv > 1) e[35:12] = tbl(lv - 1, top)[35:12];
            else        e[35:12] = 24'($urandom);
            e[0] = (($urandom % 12) != 0);
            e[1] = $urandom % 2;
            e[2] = $urandom % 2;
            e[5] = $urandom % 2;
            e[6] = $urandom % 2;
            if (lv == 2) e[7] = (($urandom % 3) == 0);
            r = $urandom % 48;
            if (r == 0) e[51] = 1'b1;
            if (r == 1) e[36] = 1'b1;
            if (r == 2) e[13] = 1'b1;
            if (r == 3 || r == 4) e[63] = 1'b1;
            put(lv, top, va, e);
        end
        run_walk(va, $urandom % 2, five, $urandom % 2, "R3 R11");
    endtask

    initial begin
        logic [56:0] va;
        void'($urandom(32'd20240611));
        va = 57'h0_1234_5678_9abc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
        chk(mem_valid == 1'b0, "R11", "reset mem idle", 64'(mem_valid), 64'd0);

        // R9: fresh path, read, both L2 and leaf get accessed
        upper_chain(va, 4);
        put(2, 4, va, link(2, 4) & ~64'h20);
        put(1, 4, va, 64'h0_ABCD_E001);
        run_walk(va, 1'b0, 1'b0, 1'b0, "R9");

        // R10: all flags already set on a write, nothing written
        upper_chain(va, 4);
        put(2, 4, va, link(2, 4));
        put(1, 4, va, 64'h0_ABCD_E063);
        run_walk(va, 1'b1, 1'b0, 1'b0, "R10");

        // R4: large page on write
        upper_chain(va, 4);
        put(2, 4, va, 64'h0_7660_0081);
        run_walk(va, 1'b1, 1'b0, 1'b0, "R4");

        // R5: level-3 entry absent
        upper_chain(va, 4);
        put(3, 4, va, 64'h0_0020_2020);
        run_walk(va, 1'b0, 1'b0, 1'b1, "R5");

        // R6: bit 36 at the top level
        upper_chain(va, 4);
        put(4, 4, va, link(4, 4) | (64'd1 << 36));
        run_walk(va, 1'b0, 1'b0, 1'b1, "R6");

        // R6: bit 13 on a large page faults
        upper_chain(va, 4);
        put(2, 4, va, 64'h0_0040_2081);
        run_walk(va, 1'b0, 1'b0, 1'b1, "R6");

        // R6: bit 13 on a table-pointing level-2 entry is harmless
        upper_chain(va, 4);
        put(2, 4, va, link(2, 4) | 64'h2000);
        put(1, 4, va, 64'h0_1111_1021);
        run_walk(va, 1'b0, 1'b0, 1'b1, "R6");

        // R7: bit 63 with the enable off, then on
        upper_chain(va, 4);
        put(2, 4, va, link(2, 4));
        put(1, 4, va, 64'h8000_0000_2222_2001);
        run_walk(va, 1'b0, 1'b0, 1'b0, "R7");
        upper_chain(va, 4);
        put(2, 4, va, link(2, 4));
        put(1, 4, va, 64'h8000_0000_2222_2001);
        run_walk(va, 1'b0, 1'b0, 1'b1, "R7");

        // R8: pass through fresh L2, leaf absent
        upper_chain(va, 4);
        put(2, 4, va, link(2, 4) & ~64'h20);
        put(1, 4, va, 64'h0_3333_3060);
        run_walk(va, 1'b1, 1'b0, 1'b1, "R8");

        // R2 R3: five-level walk
        va = 57'h1AB_CDEF_0123_4567;
        upper_chain(va, 5);
        put(2, 5, va, link(2, 5));
        put(1, 5, va, 64'h0_4444_4003);
        run_walk(va, 1'b1, 1'b1, 1'b0, "R2 R3");

        for (int i = 0; i < 400; i++) random_walk();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule